// File: doc/BRIEF.md
# Cascaded Halfband Decimator

This block reduces the sample rate of a signed 16-bit oversampled stream by a factor chosen at run time. Three halfband FIR stages sit in series, each dropping every other sample, and a rate selector chooses which point of the chain feeds the output. The choices are the unfiltered input (1x) or the output of the first (2x), second (4x) or third (8x) stage. Each filtered word is rounded and clipped to 16 bits.

The chosen stream is captured in a 16-bit two's-complement output register. A one-cycle data-ready pulse marks each new word, and an out-of-range flag travels with it. That flag gathers the converter's own overload input and every saturation event seen along the chosen path. The data pins are driven only while the chip select is low and the read line is high; at all other times they float.

A small three-state machine runs the output register. The states are `OUT_EMPTY` (no word since reset), `OUT_SHOW` (a new word is present and the pulse is high) and `OUT_HOLD` (the last word is held and the pulse is low). It moves from `OUT_EMPTY` to `OUT_SHOW` on the first selected word and from `OUT_SHOW` to `OUT_SHOW` on each further word. It moves from `OUT_SHOW` to `OUT_HOLD` when a cycle brings no word, and from `OUT_HOLD` back to `OUT_SHOW` on the next word.

Top module: `hb_decimator`

## Requirements
- R1: With `rate_sel` = 0, every input sample taken with `in_valid` high appears on the output with `dav` high in the next cycle. A change of `rate_sel` applies from the next word onward, with no reset needed.
- R2: With `rate_sel` = 1, each word is the first stage's result. That stage has 23 taps: the centre tap is 32768, and side taps sit only at odd distances from the centre. Each tap product is summed, 32768 is added, and the sum is shifted right arithmetically by 16. A word is emitted on each odd 0-based input index that is 22 or higher.
- R3: With `rate_sel` = 2, the words of stage one feed stage two. Stage two has 11 taps and uses the same arithmetic, emitting on odd indices of 10 or higher.
- R4: With `rate_sel` = 3, the words of stage two feed stage three. Stage three has 107 taps and uses the same arithmetic, emitting on odd indices of 106 or higher.
- R5: A stage result above 32767 or below -32768 is clipped to that limit, and the word carries `otr` high.
- R6: In 1x mode `otr` equals the `in_ovr` value of the sample. In filtered modes, a stage's word flag is the OR of three things: its own clipping, the flag of the input that completes the word, and the flags of all inputs since that stage's previous word.
- R7: `dav` is high for exactly one cycle per word, and the number of words matches the emission rules. In a filtered mode held steady, `dav` is never high on two cycles in a row.
- R8: While `rst_n` is low, `dav` and `otr` are low. Reset clears every delay line, fill count and phase, so the first words after reset match a fresh start.
- R9: `dout_oe` is high only when `cs_n` is low and `rd` is high, and `dout` then carries the held word. Otherwise `dout` is high-impedance. The word does not change between `dav` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| in_ovr | input | 1 | Converter overload for this sample |
| rate_sel | input | 2 | 0 = 1x, 1 = 2x, 2 = 4x, 3 = 8x |
| cs_n | input | 1 | Chip select, active low |
| rd | input | 1 | Read enable; low floats the data pins |
| dout | output | 16 | Output word, high-impedance when disabled |
| dout_oe | output | 1 | High while `dout` is driven |
| dav | output | 1 | One-cycle new-word pulse |
| otr | output | 1 | Out-of-range flag of the held word |

## Verification
Each stage result is registered, so the output is due a fixed number of clock edges after the sample that completes the word is captured. In 1x mode the word arrives one edge later; each selected stage adds one edge, so 2x takes two, 4x three and 8x four. The bench drives inputs on the falling edge and samples on the falling edge that follows, which places each comparison after the register that produced the word. A behavioural model convolves and decimates the whole input list in advance. On every clock, any `dav` must pop the next expected word and flag, and after the last input the expected queue must be empty.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    typedef enum logic [1:0] {
        RATE_X1 = 2'd0,
        RATE_X2 = 2'd1,
        RATE_X4 = 2'd2,
        RATE_X8 = 2'd3
    } rate_e;

    typedef enum logic [1:0] {
        OUT_EMPTY = 2'd0,
        OUT_SHOW  = 2'd1,
        OUT_HOLD  = 2'd2
    } out_state_e;

    // Coefficients are scaled by 2**COEF_SHIFT; the centre tap is half of unity.
    localparam int COEF_SHIFT = 16;

    // Side taps, nearest to the centre first; one side sums to a quarter of unity.
    localparam int S1_SIDE_DEF [6] = '{20720, -6600, 3400, -1800, 900, -236};
    localparam int S2_SIDE_DEF [3] = '{19600, -3900, 684};
    localparam int S3_SIDE_DEF [27] = '{
        20849, -6900, 4100, -2900, 2200, -1750, 1420, -1170, 970,
        -810, 680, -570, 480, -400, 330, -270, 220, -175,
        140, -108, 82, -60, 42, -28, 18, -10, 4
    };

endpackage

// File: rtl/hbd_stage.sv
module hbd_stage #(
    parameter int DW     = 16,
    parameter int NTAP   = 23,
    parameter int CSHIFT = 16,
    parameter int NSIDE  = (NTAP + 1) / 4,
    parameter int SIDE [NSIDE] = '{default: 0}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_valid,
    input  logic signed [DW-1:0] s_data,
    input  logic                 s_ovr,
    output logic                 m_valid,
    output logic signed [DW-1:0] m_data,
    output logic                 m_ovr
);

    localparam int CTR = (NTAP - 1) / 2;
    localparam int AW  = DW + CSHIFT + $clog2(NTAP) + 4;
    localparam int CW  = $clog2(NTAP + 1);
    localparam logic signed [AW-1:0] CENTER     = AW'(2 ** (CSHIFT - 1));
    localparam logic signed [AW-1:0] ROUND_BIAS = AW'(2 ** (CSHIFT - 1));
    localparam logic signed [AW-1:0] MAXV       = AW'(2 ** (DW - 1) - 1);
    localparam logic signed [AW-1:0] MINV       = AW'(-(2 ** (DW - 1)));

    logic signed [DW-1:0] dly_q [NTAP-1];
    logic signed [DW-1:0] win   [NTAP];
    logic signed [AW-1:0] prod  [NSIDE];
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] rnd;
    logic signed [DW-1:0] y_clip;
    logic                 y_sat;
    logic                 phase_q;
    logic [CW-1:0]        cnt_q;
    logic                 pend_q;
    logic                 emit;

    // Window as it will stand once the current sample is shifted in.
    always_comb begin
        win[0] = s_data;
        for (int i = 1; i < NTAP; i++) begin
            win[i] = dly_q[i-1];
        end
    end

    // Mirrored samples are pre-added; zero taps get no hardware.
    for (genvar j = 0; j < NSIDE; j++) begin : g_tap
        localparam int LO = CTR - 1 - 2 * j;
        localparam int HI = CTR + 1 + 2 * j;
        logic signed [DW:0] pair;
        assign pair    = (DW + 1)'(win[LO]) + (DW + 1)'(win[HI]);
        assign prod[j] = AW'(pair) * AW'(SIDE[j]);
    end

    always_comb begin
        acc = CENTER * AW'(win[CTR]);
        for (int j = 0; j < NSIDE; j++) begin
            acc = acc + prod[j];
        end
    end

    assign rnd = (acc + ROUND_BIAS) >>> CSHIFT;

    always_comb begin
        y_sat  = 1'b0;
        y_clip = rnd[DW-1:0];
        if (rnd > MAXV) begin
            y_sat  = 1'b1;
            y_clip = MAXV[DW-1:0];
        end else if (rnd < MINV) begin
            y_sat  = 1'b1;
            y_clip = MINV[DW-1:0];
        end
    end

    assign emit = s_valid && phase_q && (cnt_q >= CW'(NTAP - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NTAP - 1; i++) begin
                dly_q[i] <= '0;
            end
            phase_q <= 1'b0;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
            m_valid <= 1'b0;
            m_data  <= '0;
            m_ovr   <= 1'b0;
        end else begin
            m_valid <= emit;
            if (s_valid) begin
                dly_q[0] <= s_data;
                for (int i = 1; i < NTAP - 1; i++) begin
                    dly_q[i] <= dly_q[i-1];
                end
                phase_q <= ~phase_q;
                if (cnt_q < CW'(NTAP)) begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
            if (emit) begin
                m_data <= y_clip;
                m_ovr  <= y_sat | pend_q | s_ovr;
                pend_q <= 1'b0;
            end else if (s_valid) begin
                pend_q <= pend_q | s_ovr;
            end
        end
    end

endmodule

// File: rtl/hbd_outreg.sv
module hbd_outreg
    import hbd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_valid,
    input  logic signed [DW-1:0] sel_data,
    input  logic                 sel_ovr,
    input  logic                 cs_n,
    input  logic                 rd,
    output logic        [DW-1:0] dout,
    output logic                 dout_oe,
    output logic                 dav,
    output logic                 otr
);

    out_state_e           state_q;
    out_state_e           state_d;
    logic signed [DW-1:0] word_q;
    logic                 otr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_EMPTY: if (sel_valid) state_d = OUT_SHOW;
            OUT_SHOW:  state_d = sel_valid ? OUT_SHOW : OUT_HOLD;
            OUT_HOLD:  if (sel_valid) state_d = OUT_SHOW;
            default:   state_d = OUT_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            otr_q  <= 1'b0;
        end else if (sel_valid) begin
            word_q <= sel_data;
            otr_q  <= sel_ovr;
        end
    end

    assign dav     = (state_q == OUT_SHOW);
    assign otr     = otr_q;
    assign dout_oe = !cs_n && rd;
    assign dout    = dout_oe ? word_q : 'z;

endmodule

// File: rtl/hb_decimator.sv
module hb_decimator
    import hbd_pkg::*;
#(
    parameter int DW      = 16,
    parameter int CSHIFT  = COEF_SHIFT,
    parameter int S1_TAPS = 23,
    parameter int S2_TAPS = 11,
    parameter int S3_TAPS = 107,
    parameter int S1_SIDE [(S1_TAPS + 1) / 4] = S1_SIDE_DEF,
    parameter int S2_SIDE [(S2_TAPS + 1) / 4] = S2_SIDE_DEF,
    parameter int S3_SIDE [(S3_TAPS + 1) / 4] = S3_SIDE_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_data,
    input  logic                 in_ovr,
    input  logic [1:0]           rate_sel,
    input  logic                 cs_n,
    input  logic                 rd,
    output logic [DW-1:0]        dout,
    output logic                 dout_oe,
    output logic                 dav,
    output logic                 otr
);

    logic                 v1, v2, v3;
    logic signed [DW-1:0] d1, d2, d3;
    logic                 o1, o2, o3;
    logic                 sel_valid;
    logic signed [DW-1:0] sel_data;
    logic                 sel_ovr;
    rate_e                rate;

    hbd_stage #(.DW(DW), .NTAP(S1_TAPS), .CSHIFT(CSHIFT), .SIDE(S1_SIDE)) u_s1 (
        .clk(clk), .rst_n(rst_n),
        .s_valid(in_valid), .s_data(in_data), .s_ovr(in_ovr),
        .m_valid(v1), .m_data(d1), .m_ovr(o1)
    );

    hbd_stage #(.DW(DW), .NTAP(S2_TAPS), .CSHIFT(CSHIFT), .SIDE(S2_SIDE)) u_s2 (
        .clk(clk), .rst_n(rst_n),
        .s_valid(v1), .s_data(d1), .s_ovr(o1),
        .m_valid(v2), .m_data(d2), .m_ovr(o2)
    );

    hbd_stage #(.DW(DW), .NTAP(S3_TAPS), .CSHIFT(CSHIFT), .SIDE(S3_SIDE)) u_s3 (
        .clk(clk), .rst_n(rst_n),
        .s_valid(v2), .s_data(d2), .s_ovr(o2),
        .m_valid(v3), .m_data(d3), .m_ovr(o3)
    );

    assign rate = rate_e'(rate_sel);

    always_comb begin
        unique case (rate)
            RATE_X1: begin sel_valid = in_valid; sel_data = in_data; sel_ovr = in_ovr; end
            RATE_X2: begin sel_valid = v1;       sel_data = d1;      sel_ovr = o1;     end
            RATE_X4: begin sel_valid = v2;       sel_data = d2;      sel_ovr = o2;     end
            RATE_X8: begin sel_valid = v3;       sel_data = d3;      sel_ovr = o3;     end
            default: begin sel_valid = 1'b0;     sel_data = '0;      sel_ovr = 1'b0;   end
        endcase
    end

    hbd_outreg #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n),
        .sel_valid(sel_valid), .sel_data(sel_data), .sel_ovr(sel_ovr),
        .cs_n(cs_n), .rd(rd),
        .dout(dout), .dout_oe(dout_oe), .dav(dav), .otr(otr)
    );

endmodule

// File: rtl/hbd_decim_chk.sv
module hbd_decim_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [DW-1:0] in_data,
    input logic          in_ovr,
    input logic [1:0]    rate_sel,
    input logic [DW-1:0] dout,
    input logic          dout_oe,
    input logic          dav,
    input logic          otr
);

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!dav && !otr));

    // R1
    pass_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rate_sel) == 2'd0 && $past(in_valid)) |-> dav);

    // R1
    pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dav && $past(rate_sel) == 2'd0 && dout_oe) |-> (dout == $past(in_data)));

    // R6
    pass_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dav && $past(rate_sel) == 2'd0) |-> (otr == $past(in_ovr)));

    // R7
    no_back2back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dav && $past(rate_sel) != 2'd0 && $stable(rate_sel)) |=> !dav);

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dav && dout_oe && $past(dout_oe)) |-> $stable(dout));

endmodule

bind hb_decimator hbd_decim_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ovr(in_ovr), .rate_sel(rate_sel), .dout(dout), .dout_oe(dout_oe),
    .dav(dav), .otr(otr)
);

// File: tb/hb_decimator_tb.sv
module hb_decimator_tb;

    localparam int T1 = 23;
    localparam int T2 = 11;
    localparam int T3 = 107;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic              in_ovr = 1'b0;
    logic [1:0]        rate_sel = 2'd0;
    logic              cs_n = 1'b0;
    logic              rd = 1'b1;
    logic [15:0]       dout;
    logic              dout_oe;
    logic              dav;
    logic              otr;

    int n_checks = 0;
    int n_fail = 0;
    int xin_d[$];
    bit xin_o[$];
    int exp_d[$];
    bit exp_o[$];
    int s1q[$], s2q[$], s3q[$];
    string cur_tag = "R1";
    bit mon_en = 1'b0;
    int dav_seen = 0;
    int otr_seen = 0;
    int last_word = 0;
    int unsigned seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    hb_decimator u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ovr(in_ovr), .rate_sel(rate_sel), .cs_n(cs_n), .rd(rd),
        .dout(dout), .dout_oe(dout_oe), .dav(dav), .otr(otr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int next_rand(input int span);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 8) % (2 * span + 1)) - span;
    endfunction

    function automatic int tap_of(input int taps, input int side[$], input int i);
        int d;
        d = i - (taps - 1) / 2;
        if (d == 0) return 32768;
        if (d < 0) d = -d;
        if (d % 2 == 1) return side[(d - 1) / 2];
        return 0;
    endfunction

    // Behavioural convolve-and-decimate model of one halfband stage.
    task automatic model_stage(input int taps, input int side[$], input int xd[$],
                               input bit xo[$], output int yd[$], output bit yo[$]);
        bit pend;
        pend = 1'b0;
        yd = {};
        yo = {};
        for (int k = 0; k < xd.size(); k++) begin
            pend = pend | xo[k];
            if ((k % 2 == 1) && (k >= taps - 1)) begin
                longint acc;
                longint r;
                bit sat;
                acc = 0;
                for (int i = 0; i < taps; i++) begin
                    acc += longint'(tap_of(taps, side, i)) * longint'(xd[k - i]);
                end
                r = (acc + 32768) >>> 16;
                sat = 1'b0;
                if (r > 32767) begin r = 32767; sat = 1'b1; end
                if (r < -32768) begin r = -32768; sat = 1'b1; end
                yd.push_back(int'(r));
                yo.push_back(sat | pend);
                pend = 1'b0;
            end
        end
    endtask

    always @(negedge clk) begin
        if (mon_en && rst_n && dav) begin
            dav_seen++;
            if (otr) otr_seen++;
            if (exp_d.size() == 0) begin
                check(1'b0, "R7", "word with none expected", int'($signed(dout)), 0);
            end else begin
                int ed;
                bit eo;
                ed = exp_d.pop_front();
                eo = exp_o.pop_front();
                check(int'($signed(dout)) == ed, cur_tag, "word", int'($signed(dout)), ed);
                check(otr == eo, "R6", "otr", otr, eo);
                last_word = ed;
            end
        end
    end

    task automatic run_case(input string tag, input int md, input int gap);
        int d1[$], d2[$], d3[$];
        bit o1[$], o2[$], o3[$];
        int total;
        model_stage(T1, s1q, xin_d, xin_o, d1, o1);
        model_stage(T2, s2q, d1, o1, d2, o2);
        model_stage(T3, s3q, d2, o2, d3, o3);
        case (md)
            0: begin exp_d = xin_d; exp_o = xin_o; end
            1: begin exp_d = d1; exp_o = o1; end
            2: begin exp_d = d2; exp_o = o2; end
            default: begin exp_d = d3; exp_o = o3; end
        endcase
        total = exp_d.size();
        cur_tag = tag;
        dav_seen = 0;
        otr_seen = 0;
        @(negedge clk);
        rate_sel = 2'(md);
        mon_en = 1'b1;
        foreach (xin_d[i]) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 16'(xin_d[i]);
            in_ovr   = xin_o[i];
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_ovr   = 1'b0;
        repeat (30) @(negedge clk);
        mon_en = 1'b0;
        // R7: one pulse per modelled word, nothing left over
        check(dav_seen == total, "R7", "word count", dav_seen, total);
        check(exp_d.size() == 0, "R7", "words missing", exp_d.size(), 0);
    endtask

    task automatic clear_input();
        xin_d = {};
        xin_o = {};
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R8
        check(dav == 1'b0, "R8", "dav in reset", dav, 0);
        check(otr == 1'b0, "R8", "otr in reset", otr, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        foreach (hbd_pkg::S1_SIDE_DEF[i]) s1q.push_back(hbd_pkg::S1_SIDE_DEF[i]);
        foreach (hbd_pkg::S2_SIDE_DEF[i]) s2q.push_back(hbd_pkg::S2_SIDE_DEF[i]);
        foreach (hbd_pkg::S3_SIDE_DEF[i]) s3q.push_back(hbd_pkg::S3_SIDE_DEF[i]);

        // R8: reset state
        repeat (3) @(negedge clk);
        check(dav == 1'b0, "R8", "dav at start", dav, 0);
        check(otr == 1'b0, "R8", "otr at start", otr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dav == 1'b0, "R8", "dav idle after reset", dav, 0);

        // R1: single-sample latency in 1x
        rate_sel = 2'd0;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'sd1234;
        @(negedge clk);
        in_valid = 1'b0;
        check(dav == 1'b1, "R1", "dav one cycle after capture", dav, 1);
        check(int'($signed(dout)) == 1234, "R1", "passthrough word", int'($signed(dout)), 1234);
        @(negedge clk);
        check(dav == 1'b0, "R7", "dav single cycle", dav, 0);

        // R1 and R6: passthrough stream with overload flags
        clear_input();
        for (int i = 0; i < 24; i++) begin
            xin_d.push_back(next_rand(30000));
            xin_o.push_back(i % 5 == 2);
        end
        run_case("R1", 0, 0);

        // R2: impulse in 2x mode reads out stage-one taps
        do_reset();
        clear_input();
        for (int i = 0; i < 100; i++) begin
            xin_d.push_back(i == 40 ? 20000 : 0);
            xin_o.push_back(1'b0);
        end
        run_case("R2", 1, 0);

        // R3: random data with gaps and sparse overloads in 4x mode
        do_reset();
        clear_input();
        for (int i = 0; i < 240; i++) begin
            xin_d.push_back(next_rand(8000));
            xin_o.push_back(i % 37 == 5);
        end
        run_case("R3", 2, 1);

        // R4: impulse through the whole chain in 8x mode
        do_reset();
        clear_input();
        for (int i = 0; i < 1700; i++) begin
            xin_d.push_back(i == 1000 ? 30000 : 0);
            xin_o.push_back(1'b0);
        end
        run_case("R4", 3, 0);

        // R5: full-scale steps clip in 2x mode
        do_reset();
        clear_input();
        for (int i = 0; i < 150; i++) begin
            xin_d.push_back(i < 30 ? 0 : (i < 90 ? 32767 : -32768));
            xin_o.push_back(1'b0);
        end
        run_case("R5", 1, 0);
        check(otr_seen > 0, "R5", "clipped words flagged", otr_seen, 1);

        // R5: full-scale step through 8x
        do_reset();
        clear_input();
        for (int i = 0; i < 1600; i++) begin
            xin_d.push_back(i < 900 ? 0 : 32767);
            xin_o.push_back(1'b0);
        end
        run_case("R5", 3, 0);

        // R9: output enable and held word
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        check(dout_oe == 1'b0, "R9", "oe with cs_n high", dout_oe, 0);
        cs_n = 1'b0;
        rd = 1'b0;
        @(negedge clk);
        check(dout_oe == 1'b0, "R9", "oe with rd low", dout_oe, 0);
        rd = 1'b1;
        @(negedge clk);
        check(dout_oe == 1'b1, "R9", "oe enabled", dout_oe, 1);
        check(int'($signed(dout)) == last_word, "R9", "held word", int'($signed(dout)), last_word);

        // R1: switch 8x to 1x without reset
        clear_input();
        for (int i = 0; i < 6; i++) begin
            xin_d.push_back(next_rand(20000));
            xin_o.push_back(i == 3);
        end
        run_case("R1", 0, 0);

        // R8: reset in the middle of filling, then a fresh impulse run
        @(negedge clk);
        rate_sel = 2'd1;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 16'(next_rand(25000));
        end
        @(negedge clk);
        in_valid = 1'b0;
        do_reset();
        clear_input();
        for (int i = 0; i < 80; i++) begin
            xin_d.push_back(i == 25 ? -18000 : 0);
            xin_o.push_back(1'b0);
        end
        run_case("R8", 1, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule